// File: doc/BRIEF.md
# Power-Up and Power-Mode Sequencer

This block controls how a metering chip comes out of power-up. It takes a supply-good comparator level and an external active-low reset. Either of them can hold the chip in an inactive state. Once the supply has stayed good for a fixed hold-off, the chip always settles into the low-power sleep mode (PSM3), whatever the two mode pins show.

Software or a host then pulls `pm1` low while `pm0` stays high. This starts the move to normal mode (PSM0). On the first cycle of that move, a one-cycle pulse reloads every configuration register with its default value, and the status register is cleared at the same time. After a fixed transition time, the reset-done bit is set and the active-low interrupt line drops. The done bit cannot be masked. It is cleared only by writing a 1 to it.

The other status bits are general event flags. They are set by `evt`, cleared by a write of 1, and reach the interrupt line only when their enable bit is high. All delays are given as clock-cycle parameters, so a bench can use short values.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `supply_ok` is low, `mode` is 0 (inactive), `status` is 0, `irq_n` is 1 and `dflt_load` is 0. A supply loss in any state returns the block to this state at the next clock edge.
- R2: `mode` becomes 1 (sleep) only after HOLD_CYC consecutive clock edges that sample both `supply_ok` and `ext_rst_n` high. A single bad edge restarts the count.
- R3: The move from inactive to sleep happens whatever the values of `pm1` and `pm0`.
- R4: In sleep, an edge that samples `pm1`=0 and `pm0`=1 makes `mode` 2 (normal) from the next cycle. Every other pin pair keeps `mode` at 1.
- R5: `dflt_load` is high for exactly the first cycle of the transition to normal mode, and `status` reads 0 in that cycle.
- R6: The done bit, `status[15]` (also on `rst_done`), stays 0 for the first XFER_CYC edges of the transition. It becomes 1 after edge XFER_CYC+1 counted from the entry edge, and `irq_n` goes low with it.
- R7: The done bit drives `irq_n` low whatever `irq_en` holds. It is cleared only by a register write with `st_wdata[15]`=1, after which `irq_n` returns high.
- R8: An edge with `evt[i]` high (i<15) sets `status[i]`. A write with `st_wdata[i]`=1 clears it. The bit pulls `irq_n` low only while `irq_en[i]` is 1.
- R9: When a set and a write-1-to-clear hit the same status bit on the same edge, the bit ends set.
- R10: A low `ext_rst_n` acts as a supply loss: the block returns to the inactive state and the hold-off starts again from zero.
- R11: During the transition and in normal mode, `pm1` and `pm0` have no effect: `mode` stays 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supply_ok | input | 1 | Supply above threshold |
| ext_rst_n | input | 1 | External reset, active low |
| pm1 | input | 1 | Mode pin 1, idles high |
| pm0 | input | 1 | Mode pin 0, idles high |
| evt | input | STAT_W | Event set pulses for status bits (bit 15 ignored) |
| irq_en | input | STAT_W | Interrupt enables (bit 15 ignored) |
| st_we | input | 1 | Status register write strobe |
| st_wdata | input | STAT_W | Write-1-to-clear data |
| mode | output | 2 | 0 inactive, 1 sleep PSM3, 2 normal PSM0 |
| dflt_load | output | 1 | One-cycle default-load pulse |
| status | output | STAT_W | Status register read value |
| rst_done | output | 1 | Done bit (status[15]) |
| irq_n | output | 1 | Interrupt, active low |

## Verification
Two kinds of event can land on the same clock edge. A status bit can be set by an event or by the end of the transition while a write-1-to-clear hits that same bit. The bench provokes this twice. First it raises `evt[2]` and writes 1 to bit 2 on one edge. Then it times a write of bit 15 to land on the final edge of the transition. In both cases it expects the bit to read 1 afterwards, and the reference model applies the same set-wins rule on every clock.

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq #(
  parameter int HOLD_CYC = 260000,
  parameter int XFER_CYC = 390000,
  parameter int STAT_W   = 16
) (
  input  logic              clk,
  input  logic              supply_ok,
  input  logic              ext_rst_n,
  input  logic              pm1,
  input  logic              pm0,
  input  logic [STAT_W-1:0] evt,
  input  logic [STAT_W-1:0] irq_en,
  input  logic              st_we,
  input  logic [STAT_W-1:0] st_wdata,
  output logic [1:0]        mode,
  output logic              dflt_load,
  output logic [STAT_W-1:0] status,
  output logic              rst_done,
  output logic              irq_n
);
  localparam int MAXC = (HOLD_CYC > XFER_CYC) ? HOLD_CYC : XFER_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int DONE = STAT_W - 1;
  localparam logic [STAT_W-1:0] DMASK = {1'b1, {(STAT_W-1){1'b0}}};

  typedef enum logic [1:0] {S_OFF, S_SLP, S_XFER, S_RUN} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [STAT_W-1:0] stat;
  logic              load_q;

  wire dead     = !supply_ok || !ext_rst_n;
  wire go       = !pm1 && pm0;
  wire hold_end = (cnt == CW'(HOLD_CYC - 1));
  wire xfer_end = (cnt == CW'(XFER_CYC - 1));

  wire [STAT_W-1:0] clr  = st_we ? st_wdata : '0;
  wire [STAT_W-1:0] setv = evt & ~DMASK;
  wire [STAT_W-1:0] nxt  = (stat & ~clr) | setv;

  always_ff @(posedge clk) begin
    if (dead) begin
      st     <= S_OFF;
      cnt    <= '0;
      stat   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      stat   <= nxt;
      unique case (st)
        S_OFF:
          if (hold_end) begin
            st  <= S_SLP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        S_SLP:
          if (go) begin
            st     <= S_XFER;
            cnt    <= '0;
            load_q <= 1'b1;
            stat   <= '0;
          end
        S_XFER:
          if (xfer_end) begin
            st   <= S_RUN;
            cnt  <= '0;
            stat <= nxt | DMASK;
          end else cnt <= cnt + 1'b1;
        default: ;
      endcase
    end
  end

  assign mode      = (st == S_OFF) ? 2'd0 : (st == S_SLP) ? 2'd1 : 2'd2;
  assign dflt_load = load_q;
  assign status    = stat;
  assign rst_done  = stat[DONE];
  assign irq_n     = ~(|(stat & (irq_en | DMASK)));

  a_r6_xfer_bound: assert property (@(posedge clk) disable iff (dead)
    (st == S_XFER) |-> (cnt < CW'(XFER_CYC)));
  a_r5_load_single: assert property (@(posedge clk) disable iff (dead)
    load_q |=> !load_q);
  a_r5_load_clean: assert property (@(posedge clk) disable iff (dead)
    load_q |-> (stat == '0) && (st == S_XFER));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (dead)
    (stat[DONE] && !(st_we && st_wdata[DONE])) |=> stat[DONE]);
  a_r6_done_source: assert property (@(posedge clk) disable iff (dead)
    $rose(stat[DONE]) |-> (st == S_RUN) && ($past(st) == S_XFER));
  a_r4_sleep_hold: assert property (@(posedge clk) disable iff (dead)
    (st == S_SLP && !go) |=> (st == S_SLP));
  a_r11_run_stays: assert property (@(posedge clk) disable iff (dead)
    (st == S_RUN) |=> (st == S_RUN));
endmodule

// File: tb/tb_pwr_mode_seq.sv
module tb_pwr_mode_seq;
  localparam int H = 8;
  localparam int X = 12;

  logic clk = 1'b0;
  logic supply_ok = 1'b0, ext_rst_n = 1'b1, pm1 = 1'b1, pm0 = 1'b1;
  logic [15:0] evt = '0, irq_en = '0, st_wdata = '0;
  logic st_we = 1'b0;
  logic [1:0] mode;
  logic dflt_load, rst_done, irq_n;
  logic [15:0] status;

  int total = 0, bad = 0;

  pwr_mode_seq #(.HOLD_CYC(H), .XFER_CYC(X), .STAT_W(16)) dut (
    .clk(clk), .supply_ok(supply_ok), .ext_rst_n(ext_rst_n), .pm1(pm1), .pm0(pm0),
    .evt(evt), .irq_en(irq_en), .st_we(st_we), .st_wdata(st_wdata),
    .mode(mode), .dflt_load(dflt_load), .status(status), .rst_done(rst_done),
    .irq_n(irq_n));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: 0 off, 1 sleep, 2 transition, 3 normal
  int m_st = 0, m_cnt = 0;
  logic [15:0] m_stat = '0;
  bit m_load = 0;

  always @(posedge clk) begin
    logic [15:0] clr, ns;
    if (!supply_ok || !ext_rst_n) begin
      m_st = 0; m_cnt = 0; m_stat = '0; m_load = 0;
    end else begin
      clr = st_we ? st_wdata : 16'h0;
      ns = (m_stat & ~clr) | (evt & 16'h7fff);
      m_load = 0;
      if (m_st == 0) begin
        if (m_cnt == H - 1) begin m_st = 1; m_cnt = 0; end else m_cnt++;
      end else if (m_st == 1) begin
        if (!pm1 && pm0) begin m_st = 2; m_cnt = 0; m_load = 1; ns = '0; end
      end else if (m_st == 2) begin
        if (m_cnt == X - 1) begin m_st = 3; ns[15] = 1'b1; end else m_cnt++;
      end
      m_stat = ns;
    end
    #5;
    begin
      int em;
      bit ei;
      em = (m_st == 0) ? 0 : (m_st == 1) ? 1 : 2;
      ei = !(m_stat[15] || |(m_stat[14:0] & irq_en[14:0]));
      chk(mode == 2'(em), "R2 model mode", mode, em);
      chk(dflt_load == m_load, "R5 model load", dflt_load, m_load);
      chk(status == m_stat, "R8 model status", status, m_stat);
      chk(irq_n == ei, "R7 model irq", irq_n, ei);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(3);
    chk(mode == 0 && irq_n && !dflt_load && status == 0, "R1 inactive", mode, 0);
    pm1 = 0; pm0 = 0;
    supply_ok = 1; tick(5);
    supply_ok = 0; tick(1);
    supply_ok = 1; tick(H - 1);
    chk(mode == 0, "R2 before hold end", mode, 0);
    tick(1);
    chk(mode == 1, "R2 hold end", mode, 1);
    chk(mode == 1, "R3 sleep with pins 00", mode, 1);
    tick(3);
    chk(mode == 1, "R4 pins 00", mode, 1);
    pm1 = 1; pm0 = 0; tick(2);
    chk(mode == 1, "R4 pins 10", mode, 1);
    pm1 = 1; pm0 = 1; tick(2);
    chk(mode == 1, "R4 pins 11", mode, 1);
    evt = 16'h0008; tick(1); evt = 0;
    chk(status == 16'h0008 && irq_n, "R8 masked flag", status, 16'h0008);
    irq_en = 16'h0008; #1;
    chk(!irq_n, "R8 enabled flag", irq_n, 0);
    irq_en = 0;
    pm1 = 0; pm0 = 1; tick(1);
    chk(mode == 2, "R4 go", mode, 2);
    chk(dflt_load && status == 0, "R5 load and clear", status, 0);
    pm1 = 1; pm0 = 0; tick(1);
    chk(!dflt_load, "R5 single pulse", dflt_load, 0);
    chk(mode == 2, "R11 pins ignored", mode, 2);
    tick(X - 2);
    chk(!rst_done && irq_n, "R6 not yet done", rst_done, 0);
    tick(1);
    chk(rst_done && !irq_n && status == 16'h8000, "R6 done", status, 16'h8000);
    pm1 = 1; pm0 = 1; tick(2);
    chk(mode == 2, "R11 normal holds", mode, 2);
    st_we = 1; st_wdata = 16'h7fff; tick(1); st_we = 0;
    chk(rst_done && !irq_n, "R7 other bits write", rst_done, 1);
    st_we = 1; st_wdata = 16'h8000; tick(1); st_we = 0;
    chk(!rst_done && irq_n, "R7 clear done", rst_done, 0);
    evt = 16'h0004; st_we = 1; st_wdata = 16'h0004; tick(1);
    evt = 0; st_we = 0;
    chk(status == 16'h0004, "R9 set wins", status, 16'h0004);
    irq_en = 16'h0004; #1;
    chk(!irq_n, "R8 enabled", irq_n, 0);
    st_we = 1; tick(1); st_we = 0;
    chk(status == 0 && irq_n, "R8 w1c", status, 0);
    ext_rst_n = 0; tick(2);
    chk(mode == 0 && status == 0 && irq_n, "R10 reset", mode, 0);
    ext_rst_n = 1; tick(H - 1);
    chk(mode == 0, "R10 hold restarts", mode, 0);
    tick(1);
    chk(mode == 1, "R10 sleep again", mode, 1);
    pm1 = 0; pm0 = 1; tick(1);
    pm1 = 1; tick(X - 1);
    st_we = 1; st_wdata = 16'h8000; tick(1); st_we = 0;
    chk(rst_done == 1, "R9 done beats clear", rst_done, 1);
    supply_ok = 0; tick(1);
    chk(mode == 0 && status == 0 && irq_n, "R1 supply loss", mode, 0);
    tick(2);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule